// File: doc/BRIEF.md
# Write Leveling Calibration Controller

This block aligns the write strobe of every byte lane of a memory interface to the memory clock that is routed past each device in turn. Each device sees the clock at a different moment, so each lane gets its own strobe delay. While leveling, the controller pulses the strobe and the memory answers on the data lines. Within a lane any of the data bits may carry the answer, so all of them are ORed into one feedback bit. After each probe the lane moves its delay one tap later. The lane stops at the first probe where the feedback is high after it has been low at least once.

The delay of a lane has two parts: a fine tap count and a coarse tap count. Each step adds one fine tap. When the fine count is at its maximum, the step becomes a coarse increment and the fine count wraps to zero. The delay line reports that it has settled by raising a ready bit. The controller then waits a settle count of cycles, pulses the strobe and samples the feedback in the next cycle. A rising `start_i` runs every lane at once. `done_o` rises when every lane has either found its edge or used up its range. The final taps and the per-lane error flags then stay fixed until the next start.

Each lane runs an independent state machine with these states: IDLE, SETTLE, PULSE, SAMPLE, STEP, WAIT, FOUND and FAIL. The transitions are:
- start: IDLE, FOUND or FAIL → SETTLE
- settle expired: SETTLE → PULSE
- probe: PULSE → SAMPLE
- edge hit: SAMPLE → FOUND
- range exhausted: SAMPLE → FAIL
- advance: SAMPLE → STEP
- step issued: STEP → WAIT
- delay ready: WAIT → SETTLE

Top module: `wrlvl_cal`

## Requirements
- R1: After reset, `done_o`, every error flag, every fine and coarse tap output, every strobe pulse and every increment output are 0.
- R2: The feedback of a lane is the OR of all DQ_W bits of its byte in `lane_fb_i`, where lane l occupies bits [l*DQ_W +: DQ_W]. A high on any one bit counts as a high.
- R3: Each lane's result depends only on its own feedback byte and its own ready bit.
- R4: The result is the first probed delay at which the feedback is 1 and an earlier probe has seen 0. At that point the linear delay equals coarse*2^FINE_W + fine, where lane l's taps are on `fine_tap_o[l*FINE_W +: FINE_W]` and `coarse_tap_o[l*COARSE_W +: COARSE_W]`.
- R5: Feedback that is high before any low has been seen is not taken as an edge. A lane whose feedback never goes low ends in error.
- R6: Each step raises exactly one of `fine_inc_o[l]` or `coarse_inc_o[l]` for one cycle. The coarse increment is used exactly when the fine tap is at its maximum, and the fine tap then wraps to 0. A sweep of n steps therefore gives floor(n/2^FINE_W) coarse increments.
- R7: A strobe pulse appears exactly `settle_cyc_i`+2 cycles after the cycle in which `start_i` or the lane's ready bit was high.
- R8: Each probe is a single-cycle strobe pulse. A lane that ends at delay d emits d+1 pulses.
- R9: A lane that reaches the maximum fine and coarse taps without an edge sets its error flag. It then holds both taps at their maximum and takes no more steps.
- R10: `done_o` is high exactly when every lane has finished. A new `start_i` clears it and runs the whole procedure again.
- R11: After `done_o`, the taps, the error flags and `done_o` hold steady and no strobe pulse is emitted, whatever the feedback does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin calibration of all lanes |
| settle_cyc_i | input | SETTLE_W | Cycles to wait after a delay change before probing |
| lane_fb_i | input | LANES*DQ_W | Data feedback bytes returned by the memory |
| tap_rdy_i | input | LANES | Per-lane delay line ready after a step |
| dqs_pulse_o | output | LANES | Per-lane strobe probe pulse |
| fine_inc_o | output | LANES | Per-lane fine delay increment |
| coarse_inc_o | output | LANES | Per-lane coarse delay increment |
| fine_tap_o | output | LANES*FINE_W | Per-lane fine tap count |
| coarse_tap_o | output | LANES*COARSE_W | Per-lane coarse tap count |
| lane_err_o | output | LANES | Per-lane no-edge error flag |
| done_o | output | 1 | All lanes finished |

## Verification
The bench sweeps edge positions on both sides of every fine wrap boundary, at the lowest possible delay (1) and at the highest (the last tap). A controller that mis-handles the wrap would report a fine tap of 0 with the wrong coarse count. A controller that checks the range before sampling would fail a lane that should succeed at the last tap. Lanes that start high, stay high throughout, or never rise are mixed with normal lanes, and the feedback moves to a different bit in each scenario. These cases catch a design that accepts an edge at tap zero, reads only one fixed bit of the byte, or lets one lane's finish disturb another lane. Every strobe pulse is timed against the preceding ready or start, so an off-by-one in the settle count is caught. After `done_o`, the feedback is forced high to show that the results stay frozen.

// File: rtl/wrlvl_pkg.sv
package wrlvl_pkg;
    typedef enum logic [2:0] {
        LV_IDLE,
        LV_SETTLE,
        LV_PULSE,
        LV_SAMPLE,
        LV_STEP,
        LV_WAIT,
        LV_FOUND,
        LV_FAIL
    } lv_state_e;
endpackage

// File: rtl/wrlvl_fold.sv
module wrlvl_fold #(
    parameter int W = 8
) (
    input  logic [W-1:0] bits_i,
    output logic         hit_o
);
    // any bit of the byte may carry the memory's answer
    assign hit_o = |bits_i;
endmodule

// File: rtl/wrlvl_lane.sv
module wrlvl_lane
    import wrlvl_pkg::*;
#(
    parameter int DQ_W     = 8,
    parameter int FINE_W   = 6,
    parameter int COARSE_W = 3,
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go_i,
    input  logic [SETTLE_W-1:0] settle_i,
    input  logic [DQ_W-1:0]     fb_i,
    input  logic                rdy_i,
    output logic                pulse_o,
    output logic                fine_inc_o,
    output logic                coarse_inc_o,
    output logic [FINE_W-1:0]   fine_o,
    output logic [COARSE_W-1:0] coarse_o,
    output logic                err_o,
    output logic                fin_o
);
    localparam logic [FINE_W-1:0]   FMAX = '1;
    localparam logic [COARSE_W-1:0] CMAX = '1;

    lv_state_e           st_q, st_d;
    logic [SETTLE_W-1:0] cnt_q;
    logic                seen0_q;
    logic                fb_hit;
    logic                at_max;

    wrlvl_fold #(.W(DQ_W)) u_fold (.bits_i(fb_i), .hit_o(fb_hit));

    assign at_max = (fine_o == FMAX) && (coarse_o == CMAX);

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LV_IDLE, LV_FOUND, LV_FAIL: if (go_i) st_d = LV_SETTLE;
            LV_SETTLE: if (cnt_q == '0) st_d = LV_PULSE;
            LV_PULSE:  st_d = LV_SAMPLE;
            LV_SAMPLE: begin
                if (fb_hit && seen0_q) st_d = LV_FOUND;
                else if (at_max)       st_d = LV_FAIL;
                else                   st_d = LV_STEP;
            end
            LV_STEP: st_d = LV_WAIT;
            LV_WAIT: if (rdy_i) st_d = LV_SETTLE;
            default: st_d = LV_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= LV_IDLE;
            cnt_q    <= '0;
            seen0_q  <= 1'b0;
            fine_o   <= '0;
            coarse_o <= '0;
            err_o    <= 1'b0;
        end else begin
            st_q <= st_d;
            unique case (st_q)
                LV_IDLE, LV_FOUND, LV_FAIL: if (go_i) begin
                    cnt_q    <= settle_i;
                    seen0_q  <= 1'b0;
                    fine_o   <= '0;
                    coarse_o <= '0;
                    err_o    <= 1'b0;
                end
                LV_SETTLE: if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
                LV_SAMPLE: begin
                    if (!fb_hit) seen0_q <= 1'b1;
                    if (!(fb_hit && seen0_q) && at_max) err_o <= 1'b1;
                end
                LV_STEP: begin
                    if (fine_o == FMAX) begin
                        fine_o   <= '0;
                        coarse_o <= coarse_o + 1'b1;
                    end else begin
                        fine_o <= fine_o + 1'b1;
                    end
                end
                LV_WAIT: if (rdy_i) cnt_q <= settle_i;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        pulse_o      = (st_q == LV_PULSE);
        fine_inc_o   = (st_q == LV_STEP) && (fine_o != FMAX);
        coarse_inc_o = (st_q == LV_STEP) && (fine_o == FMAX);
        fin_o        = (st_q == LV_FOUND) || (st_q == LV_FAIL);
    end

    assert_one_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(fine_inc_o && coarse_inc_o));
    assert_coarse_on_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        coarse_inc_o |=> (fine_o == '0));
    assert_step_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fine_inc_o || coarse_inc_o) |=> !(fine_inc_o || coarse_inc_o));
    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);
    assert_err_at_max_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (fine_o == FMAX && coarse_o == CMAX));
    assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !go_i) |=> (err_o && !pulse_o && !fine_inc_o && !coarse_inc_o));
endmodule

// File: rtl/wrlvl_cal.sv
module wrlvl_cal #(
    parameter int LANES    = 4,
    parameter int DQ_W     = 8,
    parameter int FINE_W   = 6,
    parameter int COARSE_W = 3,
    parameter int SETTLE_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [SETTLE_W-1:0]        settle_cyc_i,
    input  logic [LANES*DQ_W-1:0]      lane_fb_i,
    input  logic [LANES-1:0]           tap_rdy_i,
    output logic [LANES-1:0]           dqs_pulse_o,
    output logic [LANES-1:0]           fine_inc_o,
    output logic [LANES-1:0]           coarse_inc_o,
    output logic [LANES*FINE_W-1:0]    fine_tap_o,
    output logic [LANES*COARSE_W-1:0]  coarse_tap_o,
    output logic [LANES-1:0]           lane_err_o,
    output logic                       done_o
);
    logic [LANES-1:0] lane_fin;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        wrlvl_lane #(
            .DQ_W(DQ_W), .FINE_W(FINE_W),
            .COARSE_W(COARSE_W), .SETTLE_W(SETTLE_W)
        ) u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .go_i        (start_i),
            .settle_i    (settle_cyc_i),
            .fb_i        (lane_fb_i[l*DQ_W +: DQ_W]),
            .rdy_i       (tap_rdy_i[l]),
            .pulse_o     (dqs_pulse_o[l]),
            .fine_inc_o  (fine_inc_o[l]),
            .coarse_inc_o(coarse_inc_o[l]),
            .fine_o      (fine_tap_o[l*FINE_W +: FINE_W]),
            .coarse_o    (coarse_tap_o[l*COARSE_W +: COARSE_W]),
            .err_o       (lane_err_o[l]),
            .fin_o       (lane_fin[l])
        );
    end

    assign done_o = &lane_fin;

    assert_hold_after_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(fine_tap_o) &&
                                  $stable(coarse_tap_o) && $stable(lane_err_o) &&
                                  (dqs_pulse_o == '0)));
    assert_start_clears_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !done_o);
endmodule

// File: tb/wrlvl_cal_bench.sv
module wrlvl_cal_bench;
    localparam int LANES = 4, DQ_W = 8, FINE_W = 3, COARSE_W = 2, SETTLE_W = 4;
    localparam int FSPAN = 1 << FINE_W;
    localparam int NPOS = FSPAN << COARSE_W;

    logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
    logic [SETTLE_W-1:0] settle_cyc_i = '0;
    logic [LANES*DQ_W-1:0] lane_fb_i;
    logic [LANES-1:0] tap_rdy_i = '0;
    logic [LANES-1:0] dqs_pulse_o, fine_inc_o, coarse_inc_o, lane_err_o;
    logic [LANES*FINE_W-1:0] fine_tap_o;
    logic [LANES*COARSE_W-1:0] coarse_tap_o;
    logic done_o;

    always #4 clk = ~clk;

    wrlvl_cal #(.LANES(LANES), .DQ_W(DQ_W), .FINE_W(FINE_W),
                .COARSE_W(COARSE_W), .SETTLE_W(SETTLE_W)) u_wrlvl_cal (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .settle_cyc_i(settle_cyc_i),
        .lane_fb_i(lane_fb_i), .tap_rdy_i(tap_rdy_i), .dqs_pulse_o(dqs_pulse_o),
        .fine_inc_o(fine_inc_o), .coarse_inc_o(coarse_inc_o), .fine_tap_o(fine_tap_o),
        .coarse_tap_o(coarse_tap_o), .lane_err_o(lane_err_o), .done_o(done_o));

    int checks = 0, fails = 0;
    int gap_checks = 0, gap_fails = 0;
    int cyc = 0;
    int pos[LANES], npulse[LANES], nfine[LANES], ncoarse[LANES], ref_cyc[LANES], rcnt[LANES];
    int hi0[LANES], thr[LANES], bitsel[LANES];
    logic force_hi = 1'b0;

    // memory model: feedback high below hi0 and at/after thr
    always_comb begin
        lane_fb_i = '0;
        for (int l = 0; l < LANES; l++)
            if (force_hi || pos[l] < hi0[l] || pos[l] >= thr[l])
                lane_fb_i[l*DQ_W + bitsel[l]] = 1'b1;
    end

    // delay line model and monitor
    always @(negedge clk) begin
        cyc++;
        for (int l = 0; l < LANES; l++) begin
            if (start_i) begin
                pos[l] = 0; npulse[l] = 0; nfine[l] = 0; ncoarse[l] = 0;
                rcnt[l] = 0; ref_cyc[l] = cyc - 1;
            end
            tap_rdy_i[l] = 1'b0;
            if (rcnt[l] == 1) begin tap_rdy_i[l] = 1'b1; ref_cyc[l] = cyc; end
            if (rcnt[l] != 0) rcnt[l]--;
            if (fine_inc_o[l] || coarse_inc_o[l]) begin
                pos[l]++; rcnt[l] = 2;
                if (fine_inc_o[l]) nfine[l]++; else ncoarse[l]++;
            end
            if (dqs_pulse_o[l]) begin
                npulse[l]++;
                gap_checks++;
                if (cyc - ref_cyc[l] != int'(settle_cyc_i) + 2) begin
                    gap_fails++;
                    $display("FAIL R7 lane %0d pulse gap actual %0d expected %0d",
                             l, cyc - ref_cyc[l], int'(settle_cyc_i) + 2);
                end
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_res(input int h, input int t);
        bit seen0 = 0;
        for (int p = 0; p < NPOS; p++) begin
            bit f = (p < h) || (p >= t);
            if (f && seen0) return p;
            if (!f) seen0 = 1;
        end
        return -1;
    endfunction

    task automatic run(input int s, input int h0, input int t0, input int h1, input int t1,
                       input int h2, input int t2, input int h3, input int t3, input int bs);
        int w;
        hi0 = '{h0, h1, h2, h3};
        thr = '{t0, t1, t2, t3};
        for (int l = 0; l < LANES; l++) bitsel[l] = (bs + 3 * l) % DQ_W;
        settle_cyc_i = SETTLE_W'(s);
        @(negedge clk); #1 start_i = 1'b1;
        @(negedge clk); #1 start_i = 1'b0;
        w = 0;
        while (!done_o && w < 20000) begin @(negedge clk); w++; end
        #2;
        check("R10 done reached", int'(done_o), 1);
        for (int l = 0; l < LANES; l++) begin
            int r = exp_res(hi0[l], thr[l]);
            int steps = (r >= 0) ? r : NPOS - 1;
            int ef = (r >= 0) ? r % FSPAN : FSPAN - 1;
            int ec = (r >= 0) ? r / FSPAN : (1 << COARSE_W) - 1;
            check("R4 R2 R3 fine tap", int'(fine_tap_o[l*FINE_W +: FINE_W]), ef);
            check("R4 coarse tap", int'(coarse_tap_o[l*COARSE_W +: COARSE_W]), ec);
            check("R9 R5 error flag", int'(lane_err_o[l]), (r < 0) ? 1 : 0);
            check("R8 pulse count", npulse[l], steps + 1);
            check("R6 coarse incs", ncoarse[l], steps / FSPAN);
            check("R6 fine incs", nfine[l], steps - steps / FSPAN);
        end
        // R11: feedback forced high, results must not move
        begin
            logic [LANES*FINE_W-1:0] f0 = fine_tap_o;
            logic [LANES*COARSE_W-1:0] c0 = coarse_tap_o;
            logic [LANES-1:0] e0 = lane_err_o;
            int p0 = npulse[0] + npulse[1] + npulse[2] + npulse[3];
            force_hi = 1'b1;
            repeat (12) @(negedge clk);
            #2;
            check("R11 fine hold", int'(fine_tap_o == f0), 1);
            check("R11 coarse hold", int'(coarse_tap_o == c0), 1);
            check("R11 err hold", int'(lane_err_o == e0), 1);
            check("R11 done hold", int'(done_o), 1);
            check("R11 no pulses", npulse[0] + npulse[1] + npulse[2] + npulse[3], p0);
            force_hi = 1'b0;
        end
    endtask

    initial begin
        for (int l = 0; l < LANES; l++) begin
            pos[l] = 0; hi0[l] = 0; thr[l] = NPOS + 8; bitsel[l] = 0;
            npulse[l] = 0; nfine[l] = 0; ncoarse[l] = 0; ref_cyc[l] = 0; rcnt[l] = 0;
        end
        repeat (3) @(negedge clk);
        check("R1 done", int'(done_o), 0);
        check("R1 taps", int'(fine_tap_o != '0 || coarse_tap_o != '0), 0);
        check("R1 err", int'(lane_err_o), 0);
        check("R1 strobes", int'(dqs_pulse_o | fine_inc_o | coarse_inc_o), 0);
        #1 rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 idle after release", int'(done_o) + int'(dqs_pulse_o), 0);
        // edges around the wrap points and at the range ends
        run(3, 0, 5, 0, 8, 0, 7, 0, 9, 0);
        run(0, 0, 1, 0, NPOS - 1, 3, 16, 0, 15, 1);
        // R5: start high, always high, never rising, early high region
        run(5, 2, 9, 0, NPOS + 4, 0, 0, 4, 6, 2);
        run(2, 0, 24, NPOS, NPOS, 5, 23, 0, 17, 5);
        run(1, 1, 2, 0, 31, 7, 8, 0, 2, 7);
        checks += gap_checks;
        fails += gap_fails;
        check("R7 pulses timed", int'(gap_checks > 0), 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule